// File: doc/BRIEF.md
# Test-Access Instruction Register with Opcode Decoder

This block is the instruction stage of a boundary-scan test access port. A TAP state machine elsewhere gives it one-cycle state strobes for the capture, shift and update phases of an instruction scan, plus a strobe for the Test-Logic-Reset state. On the test clock the block captures a fixed pattern into a 6-bit shift stage, shifts opcode bits in from the serial input toward the serial output, and copies the shifted word into a held instruction when the update strobe comes.

The held instruction is decoded into a one-hot select for the data register that sits between the serial input and output (boundary register, identification register or single-bit bypass). It is also decoded into three pin-control mode flags: drive pins from the boundary register, float all pins, or hold pins from the boundary register while scanning through bypass. Unassigned opcodes act as bypass. The reset instruction is the identification read.

Top module: `jtag_ir_core`

## Requirements
- R1: A capture strobe loads the shift stage with 101101 (bit 5 down to bit 0). The serial output then presents it least significant bit first: 1, 0, 1, 1, 0, 1.
- R2: A shift strobe moves the shift stage one place toward the serial output on each rising test-clock edge. `tdi` enters bit 5 and `tdo` always equals bit 0. With both strobes high, capture wins.
- R3: The held instruction `instr` changes only on an update strobe, when it takes the shift-stage value. Capture and shift cycles leave `instr` and every select and mode output unchanged.
- R4: Asserting `trst_n` low forces `instr` to 000010 (identification) at once. It stays there until two rising clock edges after release. A Test-Logic-Reset strobe also sets 000010 on the next rising edge and takes priority over update.
- R5: Opcode 000000 selects the boundary register and raises `mode_extest` only.
- R6: Opcode 000001 selects the boundary register with all three mode flags low.
- R7: Opcode 000010 selects the identification register with all mode flags low.
- R8: Opcode 000011 selects bypass and raises `mode_highz` only.
- R9: Opcode 111110 selects bypass and raises `mode_clamp` only.
- R10: Opcode 111111, the capture pattern 101101, and every other code (000100..101100 and 101110..111101) select bypass with all mode flags low.
- R11: Out of reset, exactly one of the three register selects is high, and at most one mode flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Active-low test reset; asserts asynchronously, releases synchronously |
| tlr_state | input | 1 | High while the TAP controller is in Test-Logic-Reset |
| capture_ir | input | 1 | Capture-IR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| update_ir | input | 1 | Update-IR state strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial data out, the shift-stage LSB |
| instr | output | 6 | Held (active) instruction |
| sel_bsr | output | 1 | Boundary register selected for data scans |
| sel_idcode | output | 1 | Identification register selected |
| sel_bypass | output | 1 | Single-bit bypass register selected |
| mode_extest | output | 1 | Pins driven from the boundary register |
| mode_highz | output | 1 | All outputs and bidirectional cells floated |
| mode_clamp | output | 1 | Pins held from boundary register while scanning bypass |

## Verification
The hardest situation to reach from the ports is a change in the shift stage that must not reach the decoded outputs. This is a complete scan of a new opcode with no update at its end. The bench first makes a known instruction active. It then runs capture and six shift cycles of a different opcode and checks the select and mode outputs before it pulses update. A second case of the same kind raises the Test-Logic-Reset strobe in the same cycle as update, and the bench checks that the identification code wins.

// File: rtl/jir_pkg.sv
package jir_pkg;
  localparam int unsigned IR_W = 6;

  localparam logic [IR_W-1:0] OP_EXTEST  = 6'b000000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 6'b000001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 6'b000010;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 6'b000011;
  localparam logic [IR_W-1:0] OP_CAPTURE = 6'b101101;
  localparam logic [IR_W-1:0] OP_CLAMP   = 6'b111110;
  localparam logic [IR_W-1:0] OP_BYPASS  = 6'b111111;

  typedef enum logic [1:0] {
    DR_BSR    = 2'd0,
    DR_IDCODE = 2'd1,
    DR_BYPASS = 2'd2
  } dr_sel_e;

  typedef struct packed {
    logic extest;
    logic highz;
    logic clamp;
  } pin_mode_t;
endpackage

// File: rtl/jir_rst_sync.sv
module jir_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/jir_shift_stage.sv
module jir_shift_stage #(
  parameter int unsigned     W   = 6,
  parameter logic [W-1:0]    CAP = 6'b101101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] sr_q,
  output logic         sout
);
  logic [W-1:0] sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = capture | shift;
    sr_d  = sr_q;
    if (capture)    sr_d = CAP;
    else if (shift) sr_d = {sin, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= CAP;
    else if (sr_en) sr_q <= sr_d;
  end

  assign sout = sr_q[0];

  assert_capture_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sr_q == CAP));

  assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !capture) |=> (sr_q[W-1] == $past(sin)) && (sr_q[W-2:0] == $past(sr_q[W-1:1])));

  assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !capture) |=> $stable(sr_q));
endmodule

// File: rtl/jir_hold_reg.sv
module jir_hold_reg #(
  parameter int unsigned  W      = 6,
  parameter logic [W-1:0] RST_OP = 6'b000010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tlr,
  input  logic         update,
  input  logic [W-1:0] sr,
  output logic [W-1:0] ir_q
);
  logic [W-1:0] ir_d;
  logic         ir_en;

  always_comb begin
    ir_en = tlr | update;
    ir_d  = ir_q;
    if (tlr)         ir_d = RST_OP;
    else if (update) ir_d = sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= RST_OP;
    else if (ir_en) ir_q <= ir_d;
  end

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr && !update) |=> $stable(ir_q));

  assert_update_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !tlr) |=> (ir_q == $past(sr)));

  assert_tlr_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (ir_q == RST_OP));
endmodule

// File: rtl/jir_decode.sv
module jir_decode
  import jir_pkg::*;
(
  input  logic [IR_W-1:0] ir,
  output dr_sel_e         dr_sel,
  output pin_mode_t       mode
);
  always_comb begin
    dr_sel = DR_BYPASS;
    mode   = '0;
    unique case (ir)
      OP_EXTEST: begin
        dr_sel      = DR_BSR;
        mode.extest = 1'b1;
      end
      OP_SAMPLE: dr_sel = DR_BSR;
      OP_IDCODE: dr_sel = DR_IDCODE;
      OP_HIGHZ:  mode.highz = 1'b1;
      OP_CLAMP:  mode.clamp = 1'b1;
      default:   dr_sel = DR_BYPASS;
    endcase
  end
endmodule

// File: rtl/jtag_ir_core.sv
module jtag_ir_core
  import jir_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tlr_state,
  input  logic            capture_ir,
  input  logic            shift_ir,
  input  logic            update_ir,
  input  logic            tdi,
  output logic            tdo,
  output logic [IR_W-1:0] instr,
  output logic            sel_bsr,
  output logic            sel_idcode,
  output logic            sel_bypass,
  output logic            mode_extest,
  output logic            mode_highz,
  output logic            mode_clamp
);
  logic            rst_n;
  logic [IR_W-1:0] sr;
  dr_sel_e         dr_sel;
  pin_mode_t       mode;

  jir_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(tck), .arst_n(trst_n), .rst_n(rst_n)
  );

  jir_shift_stage #(.W(IR_W), .CAP(OP_CAPTURE)) u_sr (
    .clk(tck), .rst_n(rst_n), .capture(capture_ir), .shift(shift_ir),
    .sin(tdi), .sr_q(sr), .sout(tdo)
  );

  jir_hold_reg #(.W(IR_W), .RST_OP(OP_IDCODE)) u_hold (
    .clk(tck), .rst_n(rst_n), .tlr(tlr_state), .update(update_ir),
    .sr(sr), .ir_q(instr)
  );

  jir_decode u_dec (
    .ir(instr), .dr_sel(dr_sel), .mode(mode)
  );

  assign sel_bsr     = (dr_sel == DR_BSR);
  assign sel_idcode  = (dr_sel == DR_IDCODE);
  assign sel_bypass  = (dr_sel == DR_BYPASS);
  assign mode_extest = mode.extest;
  assign mode_highz  = mode.highz;
  assign mode_clamp  = mode.clamp;

  assert_one_select_R11: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot({sel_bsr, sel_idcode, sel_bypass}));

  assert_one_mode_R11: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({mode_extest, mode_highz, mode_clamp}));

  assert_extest_bsr_R5: assert property (@(posedge tck) disable iff (!rst_n)
    mode_extest |-> sel_bsr);

  assert_highz_bypass_R8: assert property (@(posedge tck) disable iff (!rst_n)
    mode_highz |-> sel_bypass);

  assert_clamp_bypass_R9: assert property (@(posedge tck) disable iff (!rst_n)
    mode_clamp |-> sel_bypass);

  assert_idcode_sel_R7: assert property (@(posedge tck) disable iff (!rst_n)
    sel_idcode |-> (instr == OP_IDCODE));
endmodule

// File: tb/sim_jtag_ir_core.sv
`timescale 1ns/1ps
module sim_jtag_ir_core;
  logic       tck = 1'b0;
  logic       trst_n, tlr_state, capture_ir, shift_ir, update_ir, tdi;
  logic       tdo;
  logic [5:0] instr;
  logic       sel_bsr, sel_idcode, sel_bypass, mode_extest, mode_highz, mode_clamp;

  int n_checks = 0;
  int n_errors = 0;
  logic [5:0] cap_seen;

  always #10 tck = ~tck;

  jtag_ir_core u0 (
    .tck(tck), .trst_n(trst_n), .tlr_state(tlr_state), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .tdi(tdi), .tdo(tdo), .instr(instr),
    .sel_bsr(sel_bsr), .sel_idcode(sel_idcode), .sel_bypass(sel_bypass),
    .mode_extest(mode_extest), .mode_highz(mode_highz), .mode_clamp(mode_clamp)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {sel_bsr, sel_idcode, sel_bypass, extest, highz, clamp} per R5..R10
  function automatic logic [5:0] expect_dec(logic [5:0] op);
    case (op)
      6'b000000: return 6'b100_100;
      6'b000001: return 6'b100_000;
      6'b000010: return 6'b010_000;
      6'b000011: return 6'b001_010;
      6'b111110: return 6'b001_001;
      default:   return 6'b001_000;
    endcase
  endfunction

  function automatic logic [5:0] outs();
    return {sel_bsr, sel_idcode, sel_bypass, mode_extest, mode_highz, mode_clamp};
  endfunction

  task automatic scan_op(logic [5:0] op, bit do_update);
    @(negedge tck); capture_ir = 1'b1;
    @(negedge tck); capture_ir = 1'b0; shift_ir = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tdi = op[i];
      cap_seen[i] = tdo;
      @(negedge tck);
    end
    shift_ir = 1'b0;
    if (do_update) begin
      update_ir = 1'b1;
      @(negedge tck); update_ir = 1'b0;
    end
  endtask

  task automatic t_reset();
    trst_n = 1'b0; tlr_state = 0; capture_ir = 0; shift_ir = 0; update_ir = 0; tdi = 0;
    repeat (3) @(negedge tck);
    check("R4 reset instr", instr, 6'b000010);
    check("R4 reset selects", outs(), 6'b010_000);
    trst_n = 1'b1;
    repeat (3) @(negedge tck);
    check("R11 idle one-hot", outs(), 6'b010_000);
  endtask

  task automatic t_capture();
    scan_op(6'b000000, 1'b1);
    check("R1 captured bits", cap_seen, 6'b101101);
    check("R5 extest", outs(), expect_dec(6'b000000));
  endtask

  task automatic t_shift_path();
    // shift 110100 in, then capture-free shift of another word reads it back
    scan_op(6'b110100, 1'b0);
    shift_ir = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tdi = 1'b0;
      check("R2 serial readback", tdo, (6'b110100 >> i) & 1);
      @(negedge tck);
    end
    shift_ir = 1'b0;
    // both strobes: capture wins
    capture_ir = 1'b1; shift_ir = 1'b1; tdi = 1'b0;
    @(negedge tck); capture_ir = 1'b0; shift_ir = 1'b0;
    check("R2 capture priority", tdo, 1'b1);
  endtask

  task automatic t_hold();
    scan_op(6'b000011, 1'b1);
    check("R8 highz", outs(), expect_dec(6'b000011));
    scan_op(6'b111110, 1'b0);
    check("R3 no update instr", instr, 6'b000011);
    check("R3 no update outputs", outs(), expect_dec(6'b000011));
    @(negedge tck); update_ir = 1'b1;
    @(negedge tck); update_ir = 1'b0;
    check("R9 clamp", outs(), expect_dec(6'b111110));
    check("R3 late update instr", instr, 6'b111110);
  endtask

  task automatic t_decode_all();
    logic [5:0] ops [8] = '{6'b000001, 6'b000010, 6'b111111, 6'b101101,
                            6'b000100, 6'b101100, 6'b101110, 6'b111101};
    for (int k = 0; k < 8; k++) begin
      scan_op(ops[k], 1'b1);
      check("R6/R7/R10 instr", instr, ops[k]);
      check(k < 2 ? "R6/R7 decode" : "R10 bypass-like decode", outs(), expect_dec(ops[k]));
      check("R11 one select", $countones(outs() >> 3), 1);
    end
  endtask

  task automatic t_tlr();
    scan_op(6'b000000, 1'b1);
    check("R5 extest again", outs(), 6'b100_100);
    scan_op(6'b111111, 1'b0);
    @(negedge tck); tlr_state = 1'b1; update_ir = 1'b1;
    @(negedge tck); tlr_state = 1'b0; update_ir = 1'b0;
    check("R4 tlr beats update", instr, 6'b000010);
    scan_op(6'b000011, 1'b1);
    #3 trst_n = 1'b0;
    #1 check("R4 async reset", instr, 6'b000010);
    @(negedge tck); trst_n = 1'b1;
    @(negedge tck); update_ir = 1'b1;
    @(negedge tck); update_ir = 1'b0;
    check("R4 held during sync release", instr, 6'b000010);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_capture();
        t_shift_path();
        t_hold();
        t_decode_all();
        t_tlr();
      end
      begin
        repeat (5000) @(posedge tck);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule